// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block watches a serial receiver and the processor's reads of its receive FIFO. It raises a flag when characters have been left in the FIFO too long. Time is measured in whole character times. One character time is the number of 16x oversample ticks that one frame of the programmed format occupies.

The flag is raised once the FIFO holds data and a set number of full character times (four plus one, so strictly more than four) have passed with no new character and no FIFO read. Receiving a character or reading the FIFO starts the count again. A start bit seen while the flag is up clears the flag and restarts the count. An empty FIFO, or either of the two enables being low, keeps the timer at zero. The flag goes to the interrupt identification logic. The FIFO itself is not part of this block.

Top module: `rxto_detect`

## Requirements
- R1: After reset, `to_pending` is low and the timer starts from zero.
- R2: One character time is (1 + D + P + 1 + S) × OVS baud ticks. D is 5, 6, 7 or 8 for `data_len` codes 0, 1, 2 and 3. P is `parity_en`. S is `two_stop`, so a second stop bit adds one bit time.
- R3: `to_pending` becomes high after the clock edge at which the ((TIMEOUT_CHARS+1) × character time)-th baud tick since the last restart is taken. It is not high before that edge.
- R4: A `char_rcvd` pulse restarts the timer, and `to_pending` is low after that edge.
- R5: A `fifo_rd` pulse restarts the timer, and `to_pending` is low after that edge.
- R6: A `start_det` pulse while `to_pending` is high clears it and restarts the timer. A `start_det` pulse while `to_pending` is low has no effect on the timer.
- R7: While `fifo_empty` is high, the timer is held at zero and `to_pending` is low.
- R8: While either `fifo_en` or `to_int_en` is low, the timer is held at zero and `to_pending` is low.
- R9: Only cycles with `baud_tick` high advance the timer.
- R10: When a restart and a baud tick arrive in the same cycle, the restart wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle 16x oversample tick |
| data_len | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| parity_en | input | 1 | Parity bit is present in the frame |
| two_stop | input | 1 | Frame has two stop bits |
| char_rcvd | input | 1 | A character was written into the receive FIFO |
| start_det | input | 1 | The receiver detected a start bit |
| fifo_rd | input | 1 | The processor read one character from the FIFO |
| fifo_empty | input | 1 | The receive FIFO is empty |
| fifo_en | input | 1 | FIFO mode is enabled |
| to_int_en | input | 1 | The receive timeout interrupt is enabled |
| to_pending | output | 1 | Character timeout is pending |

## Verification
The checks assume that the frame format inputs change only while the timer is held, that is, while the FIFO is empty or an enable is low. A format change in the middle of a count would make the tick position inside a character undefined. Every stimulus phase therefore sets a new format only with `fifo_empty` high. Event strobes are single-cycle pulses. Random phases mix long quiet stretches, which reach the timeout, with sparse reads, receptions and start bits that land before and after the flag rises. Directed runs cover the exact boundary tick for the shortest and the longest frame.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   localparam int unsigned MIN_DATA_BITS = 5;
   localparam int unsigned MAX_FRAME_BITS = 12;

   // start + data + parity + stop(s)
   function automatic int unsigned frame_bits(input logic [1:0] dlen,
                                              input logic       par,
                                              input logic       stop2);
      return 1 + MIN_DATA_BITS + 32'(dlen) + 32'(par) + 1 + 32'(stop2);
   endfunction
endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len #(
   parameter int unsigned OVS   = 16,
   parameter int unsigned TPC_W = 8
) (
   input  logic [1:0]       data_len,
   input  logic             parity_en,
   input  logic             two_stop,
   output logic [TPC_W-1:0] ticks_per_char
);
   import rxto_pkg::*;
   always_comb begin
      ticks_per_char = TPC_W'(frame_bits(data_len, parity_en, two_stop) * OVS);
   end
endmodule

// File: rtl/rxto_char_timer.sv
module rxto_char_timer #(
   parameter int unsigned TPC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [TPC_W-1:0] ticks_per_char,
   output logic             char_pulse
);
   logic [TPC_W-1:0] sub_q;
   logic [TPC_W:0]   sub_inc;
   logic             wrap;

   always_comb begin
      sub_inc    = {1'b0, sub_q} + 1'b1;
      wrap       = sub_inc >= {1'b0, ticks_per_char};
      char_pulse = tick && wrap && !clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sub_q <= '0;
      else if (clr)    sub_q <= '0;
      else if (tick)   sub_q <= wrap ? '0 : sub_inc[TPC_W-1:0];
   end
endmodule

// File: rtl/rxto_char_count.sv
module rxto_char_count #(
   parameter int unsigned TIMEOUT_CHARS = 4,
   localparam int unsigned LIMIT = TIMEOUT_CHARS + 1,
   localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic char_pulse,
   output logic expired
);
   logic [CNT_W-1:0] cnt_q;

   assign expired = (cnt_q == CNT_W'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr)                    cnt_q <= '0;
      else if (char_pulse && !expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rxto_detect.sv
module rxto_detect #(
   parameter int unsigned OVS           = 16,
   parameter int unsigned TIMEOUT_CHARS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic [1:0] data_len,
   input  logic       parity_en,
   input  logic       two_stop,
   input  logic       char_rcvd,
   input  logic       start_det,
   input  logic       fifo_rd,
   input  logic       fifo_empty,
   input  logic       fifo_en,
   input  logic       to_int_en,
   output logic       to_pending
);
   localparam int unsigned TPC_W = $clog2(rxto_pkg::MAX_FRAME_BITS * OVS + 1);

   generate
      if (OVS < 1) begin : g_bad_ovs
         $error("rxto_detect: OVS must be at least 1");
      end
      if (TIMEOUT_CHARS < 1) begin : g_bad_to
         $error("rxto_detect: TIMEOUT_CHARS must be at least 1");
      end
   endgenerate

   logic [TPC_W-1:0] tpc;
   logic             armed, clr, char_pulse, expired;

   always_comb begin
      armed      = fifo_en && to_int_en && !fifo_empty;
      to_pending = armed && expired;
      clr        = !armed || char_rcvd || fifo_rd || (start_det && to_pending);
   end

   rxto_frame_len #(.OVS(OVS), .TPC_W(TPC_W)) u_len (
      .data_len       (data_len),
      .parity_en      (parity_en),
      .two_stop       (two_stop),
      .ticks_per_char (tpc)
   );

   rxto_char_timer #(.TPC_W(TPC_W)) u_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .clr            (clr),
      .tick           (baud_tick),
      .ticks_per_char (tpc),
      .char_pulse     (char_pulse)
   );

   rxto_char_count #(.TIMEOUT_CHARS(TIMEOUT_CHARS)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .char_pulse (char_pulse),
      .expired    (expired)
   );
endmodule

// File: rtl/rxto_detect_chk.sv
module rxto_detect_chk #(
   parameter int unsigned OVS           = 16,
   parameter int unsigned TIMEOUT_CHARS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       baud_tick,
   input logic [1:0] data_len,
   input logic       parity_en,
   input logic       two_stop,
   input logic       char_rcvd,
   input logic       start_det,
   input logic       fifo_rd,
   input logic       fifo_empty,
   input logic       fifo_en,
   input logic       to_int_en,
   input logic       to_pending
);
   import rxto_pkg::*;
   int unsigned quiet_q;
   int unsigned limit;
   logic        live;

   always_comb begin
      limit = (TIMEOUT_CHARS + 1) * frame_bits(data_len, parity_en, two_stop) * OVS;
      live  = fifo_en && to_int_en && !fifo_empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet_q <= 0;
      else if (!live || char_rcvd || fifo_rd || (start_det && to_pending)) quiet_q <= 0;
      else if (baud_tick && quiet_q < limit) quiet_q <= quiet_q + 1;
   end

   AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> !to_pending); // R7
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_en && to_int_en) |=> !to_pending); // R8
   AST_RCV_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      char_rcvd |=> !to_pending); // R4
   AST_READ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !to_pending); // R5
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && to_pending) |=> !to_pending); // R6
   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_pending) |-> $past(baud_tick)); // R9
   AST_RISE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_pending) |-> (quiet_q >= limit)); // R3
endmodule

bind rxto_detect rxto_detect_chk #(.OVS(OVS), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_chk (.*);

// File: tb/rxto_detect_tb.sv
module rxto_detect_tb;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned OVS = 16;
   localparam int unsigned TOC = 4;
   localparam int unsigned MAX_CYCLES = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic [1:0] data_len = 2'd0;
   logic parity_en = 1'b0, two_stop = 1'b0;
   logic char_rcvd = 1'b0, start_det = 1'b0, fifo_rd = 1'b0;
   logic fifo_empty = 1'b1, fifo_en = 1'b0, to_int_en = 1'b0;
   logic to_pending;

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit  done = 1'b0;
   int unsigned q_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxto_detect #(.OVS(OVS), .TIMEOUT_CHARS(TOC)) u_dut (.*);

   function automatic int unsigned exp_limit(input logic [1:0] dl, input logic p, input logic s2);
      return (TOC + 1) * (2 + 5 + 32'(dl) + 32'(p) + 32'(s2)) * OVS;
   endfunction

   function automatic logic exp_pend();
      return fifo_en && to_int_en && !fifo_empty && (q_m >= exp_limit(data_len, parity_en, two_stop));
   endfunction

   // reference: one flat tick counter since last restart
   always @(posedge clk) begin
      if (!rst_n) q_m <= 0;
      else if (!(fifo_en && to_int_en && !fifo_empty) || char_rcvd || fifo_rd ||
               (start_det && exp_pend())) q_m <= 0;
      else if (baud_tick) q_m <= q_m + 1;
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic cyc(input string req);
      @(negedge clk);
      n_chk++;
      if (to_pending !== exp_pend()) begin
         n_bad++;
         $display("FAIL %s: to_pending=%b expected %b (quiet ticks %0d)", req, to_pending, exp_pend(), q_m);
      end
   endtask

   task automatic run(input int n, input int tick_pct, input string req);
      for (int i = 0; i < n; i++) begin
         baud_tick = ($urandom % 100) < tick_pct;
         cyc(req);
      end
   endtask

   task automatic pulse(ref logic sig, input logic tk, input string req);
      sig = 1'b1; baud_tick = tk;
      cyc(req);
      sig = 1'b0;
   endtask

   task automatic set_fmt(input logic [1:0] dl, input logic p, input logic s2);
      fifo_empty = 1'b1;
      cyc("R7");
      data_len = dl; parity_en = p; two_stop = s2;
      cyc("R7");
      fifo_empty = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > MAX_CYCLES) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected <= %0d", cycles, MAX_CYCLES);
            summary();
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) cyc("R1");
      rst_n = 1'b1;
      cyc("R1");
      fifo_en = 1'b1; to_int_en = 1'b1;
      // shortest frame: 7 bits, limit 560 ticks
      set_fmt(2'd0, 1'b0, 1'b0);
      run(600, 100, "R3");
      pulse(fifo_rd, 1'b1, "R5");
      run(600, 100, "R3");
      pulse(char_rcvd, 1'b1, "R4 R10");
      run(300, 100, "R4");
      pulse(start_det, 1'b1, "R6 ignored");
      run(300, 100, "R6");
      pulse(start_det, 1'b0, "R6 clears");
      run(50, 100, "R6");
      // longest frame with second stop bit: 12 bits, limit 960 ticks
      set_fmt(2'd3, 1'b1, 1'b1);
      run(1000, 100, "R2");
      set_fmt(2'd2, 1'b1, 1'b0);
      run(900, 100, "R2");
      to_int_en = 1'b0;
      run(100, 100, "R8");
      to_int_en = 1'b1; fifo_en = 1'b0;
      run(100, 100, "R8");
      fifo_en = 1'b1;
      run(1500, 50, "R9");
      fifo_empty = 1'b1;
      run(20, 100, "R7");
      fifo_empty = 1'b0;
      // constrained random phases
      for (int ph = 0; ph < 40; ph++) begin
         set_fmt(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
         for (int k = 0; k < 6; k++) begin
            run(int'($urandom % 1200), 60 + int'($urandom % 41), "R3");
            case ($urandom % 5)
               0: pulse(char_rcvd, 1'($urandom % 2), "R4");
               1: pulse(fifo_rd, 1'($urandom % 2), "R5");
               2: pulse(start_det, 1'($urandom % 2), "R6");
               3: begin fifo_empty = 1'b1; run(5, 100, "R7"); fifo_empty = 1'b0; end
               default: begin to_int_en = 1'b0; run(5, 100, "R8"); to_int_en = 1'b1; end
            endcase
         end
      end
      summary();
   end
endmodule